// File: doc/BRIEF.md
# DRAM Dynamic Termination Controller

This block is a cycle-based model of the on-die termination control inside a DDR3-style memory device. Every clock it reports which termination is applied to the data pins: none, the nominal strength, or the write strength. It also reports which 3-bit strength code is selected. The two strength codes are decoded from mode-register fields that the surrounding logic holds steady.

The external termination input is delayed by a write-latency-derived pipeline before it takes effect. That delay is shorter in the asynchronous mode used during power-down and DLL relock, because additive latency is skipped there.

When dynamic termination is enabled, each registered WRITE opens a timed window. A fixed number of cycles after the command, the output switches to the write strength. A burst-length-dependent number of cycles after the command, it returns to nominal. A WRITE that arrives while a window is open restarts the window and keeps the write strength held.

Two one-cycle flags report timing and configuration misuse:
- a termination input held high for too short a time around a write;
- a nominal code that is not legal during writes but is used while one is in flight.

Top module: `odt_term_ctrl`

## Requirements
- R1: The nominal code is {mr1_val[9], mr1_val[6], mr1_val[2]} with bit 9 as MSB. The write code is {0, mr2_val[10:9]}. term_state encodes 00 = off, 01 = nominal, 10 = write. term_code is 000 whenever term_state is off. A zero nominal code outside the write phase gives off.
- R2: Dynamic termination is enabled exactly when mr2_val[9] or mr2_val[10] is 1 and dll_off is 0.
- R3: In synchronous mode (async_mode = 0), odt_pin sampled at edge k controls termination on or off from the output after edge k+AL+CWL-2 onward.
- R4: In asynchronous mode (async_mode = 1), that delay is CWL-2 edges, with additive latency skipped.
- R5: With termination on and dynamic enabled, a WRITE registered at edge k gives the write state in the output after edge k+AL+CWL-2.
- R6: The output returns to nominal after edge k+4+AL+CWL-2 for a BC4 burst, and after edge k+6+AL+CWL-2 for a BL8 burst.
- R7: wr_cmd encodes 0 = none, 1 = WR, 2 = WR with auto-precharge, 3 = WR BC4, 4 = WR BL8, 5 = WR auto-precharge BC4, 6 = WR auto-precharge BL8, 7 = none. Codes 1 and 2 take their burst from burst_mode: 00 = fixed BL8, 10 = fixed BC4, 01 = on the fly with otf_a12 = 1 meaning BL8; 11 acts as BL8.
- R8: A WRITE while a window is open restarts the return timer from the new command and keeps the write strength without a gap.
- R9: While dll_off = 1, the write state never appears, and the write window leaves the nominal state in place.
- R10: odth_err pulses for one cycle after the edge at which odt_pin is first sampled low, if the high run (edges from the rise to the fall) was shorter than 4 when it contained only BC4 writes, or shorter than 6 when it contained any BL8 write. Runs without writes never flag.
- R11: nom_wr_err pulses together with each output cycle in which termination is on, the write phase is active, dynamic termination is disabled, and the nominal code is 4 or above (not one of RZQ/4, RZQ/2, RZQ/6).
- R12: While rst_n = 0, term_state, term_code, odth_err and nom_wr_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mr1_val | input | 16 | Mode register 1 image (nominal strength bits) |
| mr2_val | input | 16 | Mode register 2 image (write strength bits) |
| burst_mode | input | 2 | Burst length setting for plain write codes |
| dll_off | input | 1 | DLL disabled; forces write strength off |
| async_mode | input | 1 | Asynchronous termination timing (no additive latency) |
| odt_pin | input | 1 | External termination request |
| wr_cmd | input | 3 | Registered write command code |
| otf_a12 | input | 1 | On-the-fly burst select, 1 = BL8 |
| term_state | output | 2 | Applied termination: off, nominal, write |
| term_code | output | 3 | Selected strength code |
| odth_err | output | 1 | Termination hold-time violation pulse |
| nom_wr_err | output | 1 | Illegal nominal code during write pulse |

## Verification
A wrong window counter or a lost hold bit shows at term_state as a write phase that starts or ends at the wrong edge, or as a one-cycle dip to nominal between back-to-back writes. Each of these is visible within ten cycles of the command. A wrong pipeline tap shows as termination that turns on one edge early or late after every toggle of odt_pin. A stale burst-length register shows as a return to nominal two edges off. The bench compares every output on every cycle against an arithmetic model, so any such error is reported at the first cycle it reaches the ports.

// File: rtl/odt_pkg.sv
package odt_pkg;

  typedef enum logic [1:0] {
    TS_OFF = 2'b00,
    TS_NOM = 2'b01,
    TS_WR  = 2'b10
  } term_state_e;

  typedef enum logic [2:0] {
    CMD_NONE   = 3'd0,
    CMD_WR     = 3'd1,
    CMD_WRAP   = 3'd2,
    CMD_WRS4   = 3'd3,
    CMD_WRS8   = 3'd4,
    CMD_WRAPS4 = 3'd5,
    CMD_WRAPS8 = 3'd6,
    CMD_RSVD   = 3'd7
  } wr_cmd_e;

  // burst_mode field values
  localparam logic [1:0] BM_FIX8 = 2'b00;
  localparam logic [1:0] BM_OTF  = 2'b01;
  localparam logic [1:0] BM_FIX4 = 2'b10;

  // termination on/off latency in synchronous timing
  function automatic int f_odt_lat(input int al, input int cwl);
    return al + cwl - 2;
  endfunction

  // asynchronous timing skips the additive latency
  function automatic int f_odt_lat_async(input int cwl);
    return cwl - 2;
  endfunction

  function automatic int f_cnw(input int al, input int cwl);
    return f_odt_lat(al, cwl);
  endfunction

  function automatic int f_cwn(input int al, input int cwl, input bit bc4);
    return (bc4 ? 4 : 6) + f_odt_lat(al, cwl);
  endfunction

  // nominal codes 1..3 (and 0, nothing applied) are legal while writing
  function automatic bit f_nom_wr_ok(input logic [2:0] code);
    return code <= 3'd3;
  endfunction

endpackage

// File: rtl/odt_wr_decode.sv
module odt_wr_decode
  import odt_pkg::*;
(
  input  logic [2:0] wr_cmd,
  input  logic [1:0] burst_mode,
  input  logic       otf_a12,
  output logic       is_wr,
  output logic       is_bc4
);

  logic mode_bc4;

  always_comb begin
    case (burst_mode)
      BM_FIX4: mode_bc4 = 1'b1;
      BM_OTF:  mode_bc4 = ~otf_a12;
      default: mode_bc4 = 1'b0;
    endcase
  end

  always_comb begin
    is_wr  = 1'b1;
    is_bc4 = 1'b0;
    case (wr_cmd)
      CMD_WR, CMD_WRAP:     is_bc4 = mode_bc4;
      CMD_WRS4, CMD_WRAPS4: is_bc4 = 1'b1;
      CMD_WRS8, CMD_WRAPS8: is_bc4 = 1'b0;
      default:              is_wr  = 1'b0;
    endcase
  end

endmodule

// File: rtl/odt_pin_pipe.sv
module odt_pin_pipe #(
  parameter int DEPTH = 4,
  parameter int SW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pin,
  input  logic [SW-1:0] sel_lat,
  output logic          delayed
);

  logic [DEPTH-1:0] sr;

  always_ff @(posedge clk) begin
    if (!rst_n) sr[0] <= 1'b0;
    else        sr[0] <= pin;
  end

  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) sr[i] <= 1'b0;
        else        sr[i] <= sr[i-1];
      end
    end
  endgenerate

  // tap sel_lat-1 holds the pin value sampled sel_lat-1 edges ago;
  // the output register adds the final edge
  always_comb begin
    delayed = 1'b0;
    for (int j = 0; j < DEPTH; j++)
      if (sel_lat == SW'(j + 1)) delayed = sr[j];
  end

  // R3/R4: the selected latency must be a real tap
  assert_lat_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_lat >= SW'(1)) && (sel_lat <= SW'(DEPTH)));

endmodule

// File: rtl/odt_wr_window.sv
module odt_wr_window #(
  parameter int CNW  = 4,
  parameter int CWN4 = 8,
  parameter int CWN8 = 10,
  parameter int CW   = $clog2(CWN8 + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic is_wr,
  input  logic is_bc4,
  output logic in_write,
  output logic win_open
);

  localparam logic [CW-1:0] CNW_C  = CW'(CNW);
  localparam logic [CW-1:0] END4_C = CW'(CWN4);
  localparam logic [CW-1:0] END8_C = CW'(CWN8);

  logic [CW-1:0] cnt;
  logic          open_q;
  logic          bc4_q;
  logic          hold_q;
  logic [CW-1:0] end_lat;
  logic          at_end;

  assign end_lat  = bc4_q ? END4_C : END8_C;
  assign at_end   = (cnt >= end_lat);
  assign win_open = open_q && !at_end;
  assign in_write = win_open && ((cnt >= CNW_C) || hold_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      open_q <= 1'b0;
      bc4_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      hold_q <= in_write;
      if (is_wr) begin
        cnt    <= CW'(1);
        open_q <= 1'b1;
        bc4_q  <= is_bc4;
      end else if (open_q) begin
        if (at_end) open_q <= 1'b0;
        else        cnt    <= cnt + CW'(1);
      end
    end
  end

  // R5: the write phase can only begin exactly at the switch latency
  assert_wr_switch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_write) |-> (cnt == CNW_C));

  // R6: the counter never passes the return latency of its burst
  assert_no_overrun_R6: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (cnt <= end_lat));

  // R8: a write during the write phase keeps the phase on the next cycle
  assert_restart_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && in_write) |=> in_write);

endmodule

// File: rtl/odt_hold_check.sv
module odt_hold_check #(
  parameter int H4 = 4,
  parameter int H8 = 6,
  parameter int HW = $clog2(((H4 > H8) ? H4 : H8) + 2)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic is_wr,
  input  logic is_bc4,
  output logic err
);

  localparam logic [HW-1:0] CNT_MAX = {HW{1'b1}};

  logic          pin_q;
  logic [HW-1:0] hi_cnt;
  logic [HW-1:0] req_q;
  logic [HW-1:0] req_new;
  logic          rise;
  logic          fall;

  assign req_new = is_wr ? (is_bc4 ? HW'(H4) : HW'(H8)) : '0;
  assign rise    = pin && !pin_q;
  assign fall    = !pin && pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pin_q  <= 1'b0;
      hi_cnt <= '0;
      req_q  <= '0;
      err    <= 1'b0;
    end else begin
      pin_q <= pin;
      err   <= fall && (hi_cnt < req_q);
      if (rise) begin
        hi_cnt <= HW'(1);
        req_q  <= req_new;
      end else if (pin) begin
        if (hi_cnt != CNT_MAX) hi_cnt <= hi_cnt + HW'(1);
        if (req_new > req_q)   req_q  <= req_new;
      end
    end
  end

  // R10: a hold violation is only reported after the pin was sampled low
  assert_err_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !$past(pin));

  // R10: a single edge cannot produce two reports
  assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

endmodule

// File: rtl/odt_term_ctrl.sv
module odt_term_ctrl
  import odt_pkg::*;
#(
  parameter int AL  = 1,
  parameter int CWL = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] mr1_val,
  input  logic [15:0] mr2_val,
  input  logic [1:0]  burst_mode,
  input  logic        dll_off,
  input  logic        async_mode,
  input  logic        odt_pin,
  input  logic [2:0]  wr_cmd,
  input  logic        otf_a12,
  output logic [1:0]  term_state,
  output logic [2:0]  term_code,
  output logic        odth_err,
  output logic        nom_wr_err
);

  localparam int SYNC_L  = f_odt_lat(AL, CWL);
  localparam int ASYNC_L = f_odt_lat_async(CWL);
  localparam int CNW     = f_cnw(AL, CWL);
  localparam int CWN4    = f_cwn(AL, CWL, 1'b1);
  localparam int CWN8    = f_cwn(AL, CWL, 1'b0);
  localparam int SW      = $clog2(SYNC_L + 1);

  // event wires shared with the assertions
  logic          is_wr;
  logic          is_bc4;
  logic          odt_int;
  logic          in_write;
  logic          win_open;
  logic          dyn_en;
  logic [SW-1:0] sel_lat;
  logic [2:0]    nom_code;
  logic [2:0]    wr_code;

  term_state_e   state_nxt;
  logic [2:0]    code_nxt;
  logic          nerr_nxt;

  odt_wr_decode u_dec (
    .wr_cmd     (wr_cmd),
    .burst_mode (burst_mode),
    .otf_a12    (otf_a12),
    .is_wr      (is_wr),
    .is_bc4     (is_bc4)
  );

  assign sel_lat = async_mode ? SW'(ASYNC_L) : SW'(SYNC_L);

  odt_pin_pipe #(.DEPTH(SYNC_L), .SW(SW)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin     (odt_pin),
    .sel_lat (sel_lat),
    .delayed (odt_int)
  );

  odt_wr_window #(.CNW(CNW), .CWN4(CWN4), .CWN8(CWN8)) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_wr    (is_wr),
    .is_bc4   (is_bc4),
    .in_write (in_write),
    .win_open (win_open)
  );

  odt_hold_check #(.H4(4), .H8(6)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (odt_pin),
    .is_wr  (is_wr),
    .is_bc4 (is_bc4),
    .err    (odth_err)
  );

  assign nom_code = {mr1_val[9], mr1_val[6], mr1_val[2]};
  assign wr_code  = {1'b0, mr2_val[10:9]};
  assign dyn_en   = (|mr2_val[10:9]) && !dll_off;

  always_comb begin
    state_nxt = TS_OFF;
    code_nxt  = 3'd0;
    if (odt_int) begin
      if (in_write && dyn_en) begin
        state_nxt = TS_WR;
        code_nxt  = wr_code;
      end else if (nom_code != 3'd0) begin
        state_nxt = TS_NOM;
        code_nxt  = nom_code;
      end
    end
    nerr_nxt = odt_int && in_write && !dyn_en && !f_nom_wr_ok(nom_code);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      term_state <= TS_OFF;
      term_code  <= 3'd0;
      nom_wr_err <= 1'b0;
    end else begin
      term_state <= state_nxt;
      term_code  <= code_nxt;
      nom_wr_err <= nerr_nxt;
    end
  end

  // R1: only the three defined states appear
  assert_state_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
    term_state != 2'b11);

  // R1: off always carries a zero code
  assert_off_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (term_state == TS_OFF) |-> (term_code == 3'd0));

  // R2/R9: write strength requires dynamic enable at the deciding edge
  assert_wr_needs_dyn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (term_state == TS_WR) |-> $past(dyn_en));

  // R11: an illegal-code report coincides with nominal termination in use
  assert_nerr_nominal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    nom_wr_err |-> (term_state == TS_NOM));

  // R12: outputs are cleared one edge after reset is sampled
  assert_reset_clear_R12: assert property (@(posedge clk)
    !$past(rst_n) |-> (term_state == TS_OFF && !odth_err && !nom_wr_err));

endmodule

// File: tb/sim_odt_term_ctrl.sv
module sim_odt_term_ctrl;

  localparam int AL   = 1;
  localparam int CWL  = 5;
  localparam int LS   = AL + CWL - 2;
  localparam int LA   = CWL - 2;
  localparam int CNW  = LS;
  localparam int CWN4 = 4 + LS;
  localparam int CWN8 = 6 + LS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mr1_val = '0;
  logic [15:0] mr2_val = '0;
  logic [1:0]  burst_mode = 2'b00;
  logic        dll_off = 1'b0;
  logic        async_mode = 1'b0;
  logic        odt_pin = 1'b0;
  logic [2:0]  wr_cmd = 3'd0;
  logic        otf_a12 = 1'b0;
  logic [1:0]  term_state;
  logic [2:0]  term_code;
  logic        odth_err;
  logic        nom_wr_err;

  int checks = 0;
  int errors = 0;

  // model state
  int n = 0;
  bit pin_hist [0:8191];
  int wlast = -1000;
  bit wbc4 = 0;
  bit prev_inw = 0;
  bit pq = 0;
  int hic = 0;
  int hreq = 0;

  odt_term_ctrl #(.AL(AL), .CWL(CWL)) u0 (
    .clk(clk), .rst_n(rst_n), .mr1_val(mr1_val), .mr2_val(mr2_val),
    .burst_mode(burst_mode), .dll_off(dll_off), .async_mode(async_mode),
    .odt_pin(odt_pin), .wr_cmd(wr_cmd), .otf_a12(otf_a12),
    .term_state(term_state), .term_code(term_code),
    .odth_err(odth_err), .nom_wr_err(nom_wr_err));

  always #10 clk = ~clk;

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic bit is_write(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd6);
  endfunction

  // R7 decode restated from the encoding table
  function automatic bit burst_bc4(input logic [2:0] c, input logic [1:0] bm, input logic a12);
    if (c == 3'd3 || c == 3'd5) return 1'b1;
    if (c == 3'd4 || c == 3'd6) return 1'b0;
    if (bm == 2'b10) return 1'b1;
    if (bm == 2'b01) return !a12;
    return 1'b0;
  endfunction

  task automatic step(input string req);
    int lat, m, endw;
    bit on, inw, dyn, nerr, oerr, wr;
    logic [2:0] nomc, ecode;
    logic [1:0] est;
    n++;
    pin_hist[n] = odt_pin;
    lat = async_mode ? LA : LS;
    on = (n - lat >= 1) ? pin_hist[n - lat] : 1'b0;
    m = n - wlast;
    endw = wbc4 ? CWN4 : CWN8;
    inw = (m >= 1 && m < endw) ? ((m >= CNW) || prev_inw) : 1'b0;
    prev_inw = inw;
    wr = is_write(wr_cmd);
    if (wr) begin
      wlast = n;
      wbc4 = burst_bc4(wr_cmd, burst_mode, otf_a12);
    end
    dyn = (mr2_val[9] | mr2_val[10]) && !dll_off;
    nomc = {mr1_val[9], mr1_val[6], mr1_val[2]};
    est = 2'b00; ecode = 3'd0;
    if (on) begin
      if (inw && dyn) begin est = 2'b10; ecode = {1'b0, mr2_val[10:9]}; end
      else if (nomc != 0) begin est = 2'b01; ecode = nomc; end
    end
    nerr = on && inw && !dyn && (nomc >= 3'd4);
    oerr = (!odt_pin && pq) && (hic < hreq);
    if (odt_pin && !pq) begin
      hic = 1;
      hreq = wr ? (burst_bc4(wr_cmd, burst_mode, otf_a12) ? 4 : 6) : 0;
    end else if (odt_pin) begin
      if (hic < 15) hic++;
      if (wr) begin
        if (burst_bc4(wr_cmd, burst_mode, otf_a12)) begin if (hreq < 4) hreq = 4; end
        else hreq = 6;
      end
    end
    pq = odt_pin;
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (term_state !== est || term_code !== ecode || odth_err !== oerr || nom_wr_err !== nerr) begin
      errors++;
      $display("FAIL %s cycle %0d: got st=%b code=%0d odth=%b nerr=%b exp st=%b code=%0d odth=%b nerr=%b",
               req, n, term_state, term_code, odth_err, nom_wr_err, est, ecode, oerr, nerr);
    end
  endtask

  task automatic cyc(input logic [2:0] c, input string req);
    wr_cmd = c;
    step(req);
    wr_cmd = 3'd0;
  endtask

  task automatic idle(input int k, input string req);
    for (int i = 0; i < k; i++) step(req);
  endtask

  task automatic set_nom(input logic [2:0] c);
    mr1_val = '0;
    mr1_val[9] = c[2]; mr1_val[6] = c[1]; mr1_val[2] = c[0];
  endtask

  initial begin
    // R12: reset state
    repeat (3) @(negedge clk);
    odt_pin = 1'b1;
    set_nom(3'd2);
    @(posedge clk); @(negedge clk);
    checks++;
    if (term_state !== 2'b00 || term_code !== 3'd0 || odth_err !== 1'b0 || nom_wr_err !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset: got st=%b code=%0d odth=%b nerr=%b exp 00/0/0/0",
               term_state, term_code, odth_err, nom_wr_err);
    end
    odt_pin = 1'b0;
    rst_n = 1'b1;
    idle(8, "R12");

    // R1/R3: nominal code sweep with pulses in synchronous timing
    for (int c = 0; c < 8; c++) begin
      set_nom(3'(c));
      odt_pin = 1'b1; idle(3 + c % 3, "R1");
      odt_pin = 1'b0; idle(2 + c % 2, "R3");
    end
    idle(LS + 2, "R3");

    // R4: asynchronous timing, including a switch with the pipe in flight
    set_nom(3'd1);
    async_mode = 1'b1;
    idle(LS + 1, "R4");
    for (int w = 1; w < 6; w++) begin
      odt_pin = 1'b1; idle(w, "R4");
      odt_pin = 1'b0; idle(2, "R4");
    end
    odt_pin = 1'b1; idle(2, "R4");
    async_mode = 1'b0; idle(3, "R4");
    odt_pin = 1'b0; idle(LS + 2, "R4");

    // R5/R6/R7: every command code x burst setting x a12 with termination held on
    mr2_val = '0; mr2_val[10:9] = 2'b01;
    set_nom(3'd3);
    odt_pin = 1'b1; idle(LS + 1, "R5");
    for (int c = 0; c < 8; c++)
      for (int bm = 0; bm < 4; bm++)
        for (int a = 0; a < 2; a++) begin
          burst_mode = 2'(bm); otf_a12 = 1'(a);
          cyc(3'(c), "R7");
          idle(CWN8 + 1, "R6");
        end

    // R8: back-to-back writes at every spacing, mixed bursts
    for (int sp = 1; sp <= CWN8 + 1; sp++) begin
      mr2_val[10:9] = 2'(1 + sp % 3);
      cyc(3'd3, "R8");
      idle(sp - 1, "R8");
      cyc((sp % 2) ? 3'd4 : 3'd5, "R8");
      idle(CWN8 + 1, "R8");
    end

    // R2/R9: write code sweep with dll_off toggled, and disabled write code
    for (int d = 0; d < 2; d++)
      for (int wc = 0; wc < 4; wc++) begin
        dll_off = 1'(d);
        mr2_val[10:9] = 2'(wc);
        cyc(3'd6, (d != 0) ? "R9" : "R2");
        idle(CWN8 + 1, "R2");
      end
    dll_off = 1'b0;

    // R11: illegal nominal codes during writes with dynamic disabled
    mr2_val[10:9] = 2'b00;
    for (int c = 0; c < 8; c++) begin
      set_nom(3'(c));
      cyc(3'd1, "R11");
      idle(CWN8 + 1, "R11");
    end
    odt_pin = 1'b0; idle(LS + 2, "R11");

    // R10: hold time sweep, write at the rise or inside the run, or none
    set_nom(3'd2);
    mr2_val[10:9] = 2'b10;
    for (int kind = 0; kind < 4; kind++)
      for (int len = 1; len <= 8; len++) begin
        odt_pin = 1'b1;
        case (kind)
          0: cyc(3'd3, "R10");
          1: cyc(3'd4, "R10");
          2: step("R10");
          default: cyc(3'd3, "R10");
        endcase
        if (kind == 3 && len > 1) begin cyc(3'd6, "R10"); idle(len - 2, "R10"); end
        else idle(len - 1, "R10");
        odt_pin = 1'b0;
        idle(CWN8 + 2, "R10");
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule